// File: doc/BRIEF.md
# Color Combiner Stage

This block is one stage of a fixed-function fragment color combiner. Each cycle that a fragment is presented, it picks three RGBA operands (A, B and C) from a shared set of color inputs. Each operand has its own 4-bit source code. The stage then applies one arithmetic operation to every 8-bit channel and registers the RGBA8 result.

The available inputs are the interpolated primary color, four texture colors, a previous-buffer color, a constant color and the result of the preceding stage. The two fragment-lighting source codes are not fed by real lighting here. One of them returns the primary color and the other returns black. Chaining stages, texture sampling and lighting sit outside this block.

Top module: `cmb_stage`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `out_color` is all zero.
- R2: The result for an operand set presented with `in_valid` high appears on `out_color` one clock later, and `out_valid` is high in exactly those cycles that follow an `in_valid` cycle.
- R3: In a cycle with `in_valid` low, `out_color` keeps its previous value whatever the other inputs do.
- R4: Source codes select operands as follows: 0x0 gives `prim_color`, 0x3, 0x4, 0x5 and 0x6 give texture 0, 1, 2 and 3 (texture k is bits [32k+31:32k] of `tex_color`), 0xD gives `prevbuf_color`, 0xE gives `const_color` and 0xF gives `prev_color`.
- R5: Source code 0x1 (primary fragment color) yields the same value as `prim_color`.
- R6: Source code 0x2 (secondary fragment color) yields all-zero RGBA.
- R7: Source codes 0x7 through 0xC yield all-zero RGBA.
- R8: Operation code 0 (replace) outputs operand A unchanged.
- R9: Operation code 1 (saturating add) outputs min(255, A+B) per channel.
- R10: Operation code 2 (biased add) outputs A+B-128 per channel, clamped to the range 0..255.
- R11: Operation code 3 (interpolate) outputs (A*C + B*(255-C)) / 255 per channel, with the division truncating.
- R12: Operation codes 4 through 15 output all-zero RGBA.
- R13: All four channels, bytes 0 to 3 of each 32-bit color, are computed independently with the same operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| sel_a | input | 4 | Source code for operand A |
| sel_b | input | 4 | Source code for operand B |
| sel_c | input | 4 | Source code for operand C |
| op_sel | input | 4 | Operation code |
| prim_color | input | 32 | Primary color |
| tex_color | input | 128 | Four texture colors, texture k in bits [32k+31:32k] |
| prevbuf_color | input | 32 | Previous-buffer color |
| const_color | input | 32 | Constant color |
| prev_color | input | 32 | Previous stage output |
| out_valid | output | 1 | Result valid |
| out_color | output | 32 | Registered RGBA8 result |

## Verification
The assertions on operand and channel arithmetic only constrain cycles in which `in_valid` is high. Outside those cycles the selects and colors are taken as don't-care, and only the hold and valid-tracking properties apply. The stimulus changes every input on the falling edge and keeps it steady across the capturing rising edge. It always starts from a reset pulse, so the `$past` and `$stable` checks see defined history.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam int CH_W    = 8;
  localparam int NUM_CH  = 4;
  localparam int NUM_TEX = 4;
  localparam int SEL_W   = 4;
  localparam int PIX_W   = CH_W * NUM_CH;
  localparam int TEX_W   = PIX_W * NUM_TEX;
  localparam int PROD_W  = 2 * CH_W + 1;

  localparam logic [CH_W-1:0] CH_MAX  = {CH_W{1'b1}};
  localparam logic [CH_W-1:0] CH_BIAS = CH_W'(1 << (CH_W - 1));

  // operand source codes
  localparam logic [SEL_W-1:0] SRC_PRIM    = 4'h0;
  localparam logic [SEL_W-1:0] SRC_LIT0    = 4'h1;
  localparam logic [SEL_W-1:0] SRC_LIT1    = 4'h2;
  localparam logic [SEL_W-1:0] SRC_TEX0    = 4'h3;
  localparam logic [SEL_W-1:0] SRC_PREVBUF = 4'hD;
  localparam logic [SEL_W-1:0] SRC_CONST   = 4'hE;
  localparam logic [SEL_W-1:0] SRC_PREV    = 4'hF;

  // operation codes
  localparam logic [SEL_W-1:0] OP_PASS = 4'h0;
  localparam logic [SEL_W-1:0] OP_ADD  = 4'h1;
  localparam logic [SEL_W-1:0] OP_ADDB = 4'h2;
  localparam logic [SEL_W-1:0] OP_MIX  = 4'h3;

  function automatic logic [CH_W-1:0] f_sat_add(input logic [CH_W-1:0] a,
                                                input logic [CH_W-1:0] b);
    logic [CH_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CH_W] ? CH_MAX : s[CH_W-1:0];
  endfunction

  function automatic logic [CH_W-1:0] f_bias_add(input logic [CH_W-1:0] a,
                                                 input logic [CH_W-1:0] b);
    logic [CH_W:0] s;
    logic [CH_W:0] d;
    s = {1'b0, a} + {1'b0, b};
    d = s - {1'b0, CH_BIAS};
    if (s < {1'b0, CH_BIAS}) return '0;
    if (d[CH_W]) return CH_MAX;
    return d[CH_W-1:0];
  endfunction

  function automatic logic [CH_W-1:0] f_mix(input logic [CH_W-1:0] a,
                                            input logic [CH_W-1:0] b,
                                            input logic [CH_W-1:0] c);
    logic [PROD_W-1:0] num;
    logic [PROD_W-1:0] q;
    num = PROD_W'(a) * PROD_W'(c) + PROD_W'(b) * PROD_W'(CH_MAX - c);
    q   = num / PROD_W'(CH_MAX);
    return q[CH_W-1:0];
  endfunction
endpackage

// File: rtl/cmb_src_mux.sv
module cmb_src_mux
  import cmb_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [PIX_W-1:0] prim,
  input  logic [TEX_W-1:0] tex,
  input  logic [PIX_W-1:0] prevbuf,
  input  logic [PIX_W-1:0] konst,
  input  logic [PIX_W-1:0] prev,
  output logic [PIX_W-1:0] y
);
  always_comb begin
    y = '0;
    if (sel == SRC_PRIM || sel == SRC_LIT0) y = prim;
    else if (sel == SRC_LIT1)               y = '0;
    else if (sel == SRC_PREVBUF)            y = prevbuf;
    else if (sel == SRC_CONST)              y = konst;
    else if (sel == SRC_PREV)               y = prev;
    else begin
      for (int k = 0; k < NUM_TEX; k++) begin
        if (sel == SEL_W'(SRC_TEX0 + SEL_W'(k))) y = tex[k*PIX_W +: PIX_W];
      end
    end
  end
endmodule

// File: rtl/cmb_chan_alu.sv
module cmb_chan_alu
  import cmb_pkg::*;
(
  input  logic [SEL_W-1:0] op,
  input  logic [CH_W-1:0]  a,
  input  logic [CH_W-1:0]  b,
  input  logic [CH_W-1:0]  c,
  output logic [CH_W-1:0]  y
);
  always_comb begin
    case (op)
      OP_PASS: y = a;
      OP_ADD:  y = f_sat_add(a, b);
      OP_ADDB: y = f_bias_add(a, b);
      OP_MIX:  y = f_mix(a, b, c);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/cmb_stage.sv
module cmb_stage
  import cmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3:0]       sel_a,
  input  logic [3:0]       sel_b,
  input  logic [3:0]       sel_c,
  input  logic [3:0]       op_sel,
  input  logic [31:0]      prim_color,
  input  logic [127:0]     tex_color,
  input  logic [31:0]      prevbuf_color,
  input  logic [31:0]      const_color,
  input  logic [31:0]      prev_color,
  output logic             out_valid,
  output logic [31:0]      out_color
);
  localparam int N_OPND = 3;

  logic [SEL_W-1:0] sel_vec [N_OPND];
  logic [PIX_W-1:0] opnd    [N_OPND];
  logic [PIX_W-1:0] res_pix;

  assign sel_vec[0] = sel_a;
  assign sel_vec[1] = sel_b;
  assign sel_vec[2] = sel_c;

  // operand selection, one mux per operand
  for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
    cmb_src_mux u_mux (
      .sel     (sel_vec[i]),
      .prim    (prim_color),
      .tex     (tex_color),
      .prevbuf (prevbuf_color),
      .konst   (const_color),
      .prev    (prev_color),
      .y       (opnd[i])
    );
  end

  // per-channel arithmetic (R13)
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [CH_W-1:0] ch_a, ch_b, ch_c, ch_y;
    assign ch_a = opnd[0][k*CH_W +: CH_W];
    assign ch_b = opnd[1][k*CH_W +: CH_W];
    assign ch_c = opnd[2][k*CH_W +: CH_W];

    cmb_chan_alu u_alu (
      .op (op_sel),
      .a  (ch_a),
      .b  (ch_b),
      .c  (ch_c),
      .y  (ch_y)
    );
    assign res_pix[k*CH_W +: CH_W] = ch_y;

    // R9
    add_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == OP_ADD) |-> (ch_y >= ch_a && ch_y >= ch_b));

    // R10
    addb_floor_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == OP_ADDB &&
       ({1'b0, ch_a} + {1'b0, ch_b}) < {1'b0, CH_BIAS}) |-> (ch_y == '0));

    // R11
    mix_bounds_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == OP_MIX) |->
        ((ch_y >= ch_a || ch_y >= ch_b) && (ch_y <= ch_a || ch_y <= ch_b)));
  end

  // output register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_color <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_color <= res_pix;
    end
  end

  // R2
  valid_track_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_color));

  // R5
  lit0_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_a == SRC_LIT0) |-> (opnd[0] == prim_color));

  // R6
  lit1_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_b == SRC_LIT1) |-> (opnd[1] == '0));

  // R8
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_PASS) |=> (out_color == $past(opnd[0])));
endmodule

// File: tb/cmb_stage_test.sv
`timescale 1ns/1ps
module cmb_stage_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [3:0]   sel_a, sel_b, sel_c, op_sel;
  logic [31:0]  prim_color, prevbuf_color, const_color, prev_color;
  logic [127:0] tex_color;
  logic         out_valid;
  logic [31:0]  out_color;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmb_stage uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .op_sel(op_sel),
    .prim_color(prim_color), .tex_color(tex_color),
    .prevbuf_color(prevbuf_color), .const_color(const_color),
    .prev_color(prev_color), .out_valid(out_valid), .out_color(out_color)
  );

  function automatic logic [31:0] src_val(input logic [3:0] code);
    case (code)
      4'h0, 4'h1: return prim_color;
      4'h3: return tex_color[31:0];
      4'h4: return tex_color[63:32];
      4'h5: return tex_color[95:64];
      4'h6: return tex_color[127:96];
      4'hD: return prevbuf_color;
      4'hE: return const_color;
      4'hF: return prev_color;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int ch_model(input int op, input int a, input int b, input int c);
    int t;
    case (op)
      0: return a;
      1: begin t = a + b; return (t > 255) ? 255 : t; end
      2: begin t = a + b - 128; if (t < 0) t = 0; if (t > 255) t = 255; return t; end
      3: return (a * c + 255 * b - b * c) / 255;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] pix_model(input logic [3:0] op);
    logic [31:0] a, b, c, r;
    a = src_val(sel_a); b = src_val(sel_b); c = src_val(sel_c);
    for (int k = 0; k < 4; k++)
      r[k*8 +: 8] = 8'(ch_model(int'(op), int'(a[k*8 +: 8]), int'(b[k*8 +: 8]), int'(c[k*8 +: 8])));
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_one(input string tag, input logic [3:0] sa, input logic [3:0] sb,
                         input logic [3:0] sc, input logic [3:0] op);
    logic [31:0] exp;
    @(negedge clk);
    sel_a = sa; sel_b = sb; sel_c = sc; op_sel = op; in_valid = 1'b1;
    exp = pix_model(op);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    check(tag, out_color, exp);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0;
    sel_a = 0; sel_b = 0; sel_c = 0; op_sel = 0;
    repeat (3) @(negedge clk);
    check("R1 valid during reset", {31'b0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {31'b0, out_valid}, 32'd0);
    check("R1 color after reset", out_color, 32'd0);
  endtask

  task automatic t_sources;
    prim_color = 32'h40302010; prevbuf_color = 32'h0D0C0B0A;
    const_color = 32'hE1E2E3E4; prev_color = 32'hF0F1F2F3;
    tex_color = {32'h66554433, 32'h55443322, 32'h44332211, 32'h33221100};
    for (int s = 0; s < 16; s++) begin
      string tag;
      if (s == 1) tag = "R5 primary fragment alias";
      else if (s == 2) tag = "R6 secondary fragment zero";
      else if (s >= 7 && s <= 12) tag = $sformatf("R7 unused source %0h", s);
      else tag = $sformatf("R4 source %0h", s);
      run_one({tag, " R8"}, 4'(s), 4'h0, 4'h0, 4'h0);
    end
  endtask

  task automatic t_add;
    tex_color[31:0] = 32'h017F80C8; tex_color[63:32] = 32'h02808064;
    run_one("R9 saturating add R13", 4'h3, 4'h4, 4'h0, 4'h1);
    run_one("R9 add with zero source", 4'h3, 4'h2, 4'h0, 4'h1);
  endtask

  task automatic t_bias;
    prim_color = 32'h90FF8050; const_color = 32'h30FF0020;
    run_one("R10 biased add clamp", 4'h0, 4'hE, 4'h0, 4'h2);
    prim_color = 32'h01407F81; const_color = 32'h7F40017F;
    run_one("R10 biased add near bias", 4'h0, 4'hE, 4'h0, 4'h2);
  endtask

  task automatic t_mix;
    prevbuf_color = 32'hC8FF00FF; prev_color = 32'h1000FF00;
    const_color = 32'h3380FF00;
    run_one("R11 interpolate", 4'hD, 4'hF, 4'hE, 4'h3);
    prevbuf_color = 32'h7F0102FE; prev_color = 32'h80FE0301;
    const_color = 32'h01FEFE7F;
    run_one("R11 interpolate truncation", 4'hD, 4'hF, 4'hE, 4'h3);
  endtask

  task automatic t_bad_ops;
    prim_color = 32'hA5A5A5A5; prev_color = 32'h5A5A5A5A;
    for (int o = 4; o < 16; o++)
      run_one($sformatf("R12 op %0h zero", o), 4'h0, 4'hF, 4'hF, 4'(o));
  endtask

  task automatic t_hold;
    logic [31:0] kept;
    prim_color = 32'h12345678;
    run_one("R2 latency", 4'h0, 4'h0, 4'h0, 4'h0);
    kept = out_color;
    prim_color = 32'hDEADBEEF; op_sel = 4'h1; sel_a = 4'hE;
    repeat (3) @(negedge clk);
    check("R3 hold color", out_color, kept);
    check("R2 valid low when idle", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    prim_color = '0; prevbuf_color = '0; const_color = '0; prev_color = '0; tex_color = '0;
    t_reset();
    t_sources();
    t_add();
    t_bias();
    t_mix();
    t_bad_ops();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule